// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block sits between a synchronous request port and an external asynchronous static RAM of 262,144 words by 16 bits. It turns one single-word command into a sequence of strobes: chip select, write enable, output enable and two active-low byte enables. Every strobe comes straight from a flop, and each timing window is a whole number of clock cycles set by a parameter. Each window is the nanosecond minimum rounded up to clock cycles. The defaults assume a 100 MHz clock.

Writes are controlled by write enable. Output enable stays high for the whole write, so the RAM never drives the bus while the controller does. The controller drives the data bus only from the setup cycle through the cycle after write enable rises.

Reads hold output enable low for the access window. The data bus is sampled on the last cycle of that window, and the word is returned with a one-cycle valid pulse. Lanes that the request masks off come back as zero. After every read, a turnaround window keeps all strobes high before the next command is accepted.

The state machine has these states:
- `ST_IDLE`: waiting for a command.
- `ST_WR_SETUP`: chip selected, write enable still high.
- `ST_WR_PULSE`: write enable low.
- `ST_WR_HOLD`: write enable high again, chip still selected, data still driven.
- `ST_RD_ACCESS`: chip and output enable low.
- `ST_RD_TURN`: bus released.

The transitions are:
- `ST_IDLE` to `ST_WR_SETUP` on an accepted write.
- `ST_IDLE` to `ST_RD_ACCESS` on an accepted read.
- `ST_WR_SETUP` to `ST_WR_PULSE` after one cycle.
- `ST_WR_PULSE` to `ST_WR_HOLD` when the pulse window expires.
- `ST_WR_HOLD` to `ST_IDLE` after one cycle.
- `ST_RD_ACCESS` to `ST_RD_TURN` when the access window expires; the data is captured at this transition.
- `ST_RD_TURN` to `ST_IDLE` when the turnaround window expires.

All window parameters must be at least 1.

Top module: `sram_byte_ctrl`

## Requirements
- R1: Reset state:
  - After reset, `ram_cs_n`, `ram_we_n`, `ram_oe_n` and both bits of `ram_be_n` are 1.
  - `ram_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Request acceptance:
  - `req_ready` is 1 only in the idle state.
  - A command is taken on a rising edge where `req_valid` and `req_ready` are both 1.
  - While `req_valid` is 0 the strobes stay inactive.
- R3: Write strobe sequence, with `req_write`=1:
  - `ram_cs_n` goes low one cycle before `ram_we_n` falls.
  - `ram_we_n` stays low for exactly WR_PULSE_CYC cycles (default 2).
  - `ram_we_n` rises while `ram_cs_n` is held low for one more cycle; `ram_cs_n` then goes high.
  - `ram_we_n` is low only while `ram_cs_n` is low.
- R4: Write data and address:
  - `ram_dq_oe` is 1 exactly during the write's setup, pulse and hold cycles.
  - During those cycles `ram_dq_out` equals the request data.
  - `ram_addr` equals the request address and stays stable for as long as `ram_cs_n` is low.
- R5: Byte lanes:
  - `req_mask` bit 0 enables the lower lane (data bits 7:0) and bit 1 enables the upper lane (bits 15:8); 1 means enabled.
  - While `ram_cs_n` is low, `ram_be_n[i]` is the inverse of mask bit i.
  - Both bits of `ram_be_n` are 1 when idle.
- R6: Read strobe sequence, with `req_write`=0:
  - `ram_cs_n` and `ram_oe_n` are low for exactly RD_ACCESS_CYC cycles (default 3).
  - `ram_we_n` stays 1 and `ram_dq_oe` stays 0 for the whole read.
- R7: Read response:
  - `rsp_valid` is 1 for exactly one cycle, RD_ACCESS_CYC cycles after the accepting edge.
  - `rsp_rdata` holds `ram_dq_in` as sampled on the last access cycle, with masked-off lanes forced to 0.
- R8: Read turnaround: after a read, all strobes stay high for TURN_CYC cycles (default 1) before `req_ready` returns to 1.
- R9: Bus contention: `ram_we_n` and `ram_oe_n` are never low together, and `ram_dq_oe` is never 1 while `ram_oe_n` is low.
- R10: Empty mask: a command with mask 00 runs its full sequence with both bits of `ram_be_n` held at 1. A write therefore leaves the stored word unchanged, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Command valid |
| req_ready | output | 1 | Controller idle, command accepted this edge |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane enables, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| ram_addr | output | 18 | RAM address |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_be_n | output | 2 | RAM byte enables, bit 0 lower, bit 1 upper, active low |
| ram_dq_out | output | 16 | Data driven to the RAM bus |
| ram_dq_oe | output | 1 | Bus driver enable |
| ram_dq_in | input | 16 | Data read from the RAM bus |

## Verification
Each cycle is counted from the edge that accepts a command. For a write, that edge starts the setup cycle. Write enable is then low for the next WR_PULSE_CYC cycles. The hold cycle follows, and `req_ready` returns one cycle later. For a read, `ram_oe_n` is low for RD_ACCESS_CYC cycles from the accepting edge. `rsp_valid` and the data appear in the first turnaround cycle, and `req_ready` returns TURN_CYC cycles after that. The bench samples every port at the falling edge and walks these windows one cycle at a time, checking the strobes each cycle against the expected phase. The response data is compared with a reference memory that the bench keeps by applying each write's lane mask.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_TURN
    } sram_state_e;
endpackage

// File: rtl/sram_win_timer.sv
module sram_win_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    localparam int LANE_W = DATA_W / LANES;

    logic [DATA_W-1:0] keep;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign keep[g*LANE_W +: LANE_W] = {LANE_W{lane_en[g]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= capture;
            if (capture) begin
                rdata <= dq_in & keep;
            end
        end
    end
endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 18,
    parameter int DATA_W        = 16,
    parameter int WR_PULSE_CYC  = 2,
    parameter int RD_ACCESS_CYC = 3,
    parameter int TURN_CYC      = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [DATA_W/8-1:0]  req_mask,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [ADDR_W-1:0]    ram_addr,
    output logic                 ram_cs_n,
    output logic                 ram_we_n,
    output logic                 ram_oe_n,
    output logic [DATA_W/8-1:0]  ram_be_n,
    output logic [DATA_W-1:0]    ram_dq_out,
    output logic                 ram_dq_oe,
    input  logic [DATA_W-1:0]    ram_dq_in
);
    localparam int LANES  = DATA_W / 8;
    localparam int MAX_A  = (WR_PULSE_CYC > RD_ACCESS_CYC) ? WR_PULSE_CYC : RD_ACCESS_CYC;
    localparam int MAX_W  = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
    localparam int CNT_W  = (MAX_W < 2) ? 1 : $clog2(MAX_W);

    sram_state_e      state_q, state_d;
    logic             accept;
    logic             tmr_load, tmr_zero;
    logic [CNT_W-1:0] tmr_val;
    logic [LANES-1:0] mask_q, mask_nx;
    logic             capture;

    assign accept  = req_valid && (state_q == ST_IDLE);
    assign mask_nx = accept ? req_mask : mask_q;
    assign capture = (state_q == ST_RD_ACCESS) && tmr_zero;

    // next-state and window loading
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_ACCESS_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WR_PULSE_CYC - 1);
            end
            ST_WR_PULSE: begin
                if (tmr_zero) state_d = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_d = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (tmr_zero) begin
                    state_d  = ST_RD_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_RD_TURN: begin
                if (tmr_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            mask_q     <= '0;
            ram_addr   <= '0;
            ram_dq_out <= '0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_nx;
            if (accept) begin
                ram_addr   <= req_addr;
                ram_dq_out <= req_wdata;
            end
        end
    end

    // registered strobes decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ram_cs_n  <= 1'b1;
            ram_we_n  <= 1'b1;
            ram_oe_n  <= 1'b1;
            ram_be_n  <= '1;
            ram_dq_oe <= 1'b0;
            req_ready <= 1'b1;
        end else begin
            ram_cs_n  <= !(state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD, ST_RD_ACCESS});
            ram_we_n  <= (state_d != ST_WR_PULSE);
            ram_oe_n  <= (state_d != ST_RD_ACCESS);
            ram_dq_oe <= (state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD});
            req_ready <= (state_d == ST_IDLE);
            for (int i = 0; i < LANES; i++) begin
                ram_be_n[i] <= !(mask_nx[i] &&
                    (state_d inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_HOLD, ST_RD_ACCESS}));
            end
        end
    end

    sram_win_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_rd_capture #(.DATA_W(DATA_W), .LANES(LANES)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .lane_en (mask_q),
        .dq_in   (ram_dq_in),
        .rdata   (rsp_rdata),
        .rvalid  (rsp_valid)
    );
endmodule

// File: rtl/sram_byte_ctrl_chk.sv
module sram_byte_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs_n,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic [LANES-1:0]  ram_be_n,
    input logic              ram_dq_oe
);
    a_r9_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ram_we_n && !ram_oe_n));

    a_r9_no_bus_fight: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_dq_oe && !ram_oe_n));

    a_r3_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> !ram_cs_n);

    a_r3_cs_leads_we: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> $past(!ram_cs_n));

    a_r3_cs_held_at_we_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> !ram_cs_n);

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));

    a_r7_rsp_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ram_cs_n && !ram_dq_oe));

    a_r5_lanes_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
        ram_cs_n |-> (ram_be_n == '1));
endmodule

bind sram_byte_ctrl sram_byte_ctrl_chk #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .ram_addr  (ram_addr),
    .ram_cs_n  (ram_cs_n),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .ram_be_n  (ram_be_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/sram_byte_ctrl_tb_top.sv
module sram_byte_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WRP = 2;
    localparam int RDA = 3;
    localparam int TRN = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] ram_addr;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [1:0]  ram_be_n;
    logic [15:0] ram_dq_out;
    logic [15:0] ram_dq_in = 16'hDEAD;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    logic [15:0] ram_mem [int];
    logic [15:0] ref_mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_byte_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n),
        .ram_oe_n(ram_oe_n), .ram_be_n(ram_be_n), .ram_dq_out(ram_dq_out),
        .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
    );

    function automatic logic [15:0] init_word(input logic [17:0] a);
        return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h3C};
    endfunction

    function automatic logic [15:0] lane_bits(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // RAM model: writes land at the falling edge, read data settles before the next rise
    always @(negedge clk) begin
        logic [15:0] w;
        w = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : init_word(ram_addr);
        if (rst_n && !ram_cs_n && !ram_we_n && ram_dq_oe) begin
            if (!ram_be_n[0]) w[7:0]  = ram_dq_out[7:0];
            if (!ram_be_n[1]) w[15:8] = ram_dq_out[15:8];
            ram_mem[int'(ram_addr)] = w;
        end
        if (!ram_cs_n && !ram_oe_n && ram_we_n)
            ram_dq_in <= {ram_be_n[1] ? 8'hA5 : w[15:8], ram_be_n[0] ? 8'h5A : w[7:0]};
        else
            ram_dq_in <= 16'hDEAD;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // {cs,we,oe,be[1:0],dq_oe}
    task automatic chk_strobes(input string tag, input logic [5:0] exp);
        chk(tag, {26'd0, ram_cs_n, ram_we_n, ram_oe_n, ram_be_n, ram_dq_oe}, {26'd0, exp});
    endtask

    task automatic issue(input logic wr, input logic [17:0] a, input logic [15:0] d,
                         input logic [1:0] m);
        @(negedge clk);
        chk("R2 ready before command", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = $urandom; req_wdata = $urandom; req_mask = $urandom;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        logic [15:0] w;
        logic [1:0]  be;
        be = ~m;
        issue(1'b1, a, d, m);
        chk_strobes("R3 R5 write setup", {1'b0, 1'b1, 1'b1, be, 1'b1});
        chk("R4 write addr", {14'd0, ram_addr}, {14'd0, a});
        chk("R4 write data", {16'd0, ram_dq_out}, {16'd0, d});
        chk("R2 busy during write", {31'd0, req_ready}, 32'd0);
        for (int i = 0; i < WRP; i++) begin
            @(negedge clk);
            chk_strobes("R3 write pulse", {1'b0, 1'b0, 1'b1, be, 1'b1});
        end
        @(negedge clk);
        chk_strobes("R3 write hold", {1'b0, 1'b1, 1'b1, be, 1'b1});
        chk("R4 data held", {16'd0, ram_dq_out}, {16'd0, d});
        w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
        w = (w & ~lane_bits(m)) | (d & lane_bits(m));
        ref_mem[int'(a)] = w;
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m);
        logic [15:0] w;
        issue(1'b0, a, 16'h0, m);
        for (int i = 0; i < RDA; i++) begin
            if (i > 0) @(negedge clk);
            chk_strobes("R6 R5 read access", {1'b0, 1'b1, 1'b0, ~m, 1'b0});
            chk("R7 no early response", {31'd0, rsp_valid}, 32'd0);
        end
        @(negedge clk);
        w = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
        chk("R7 response valid", {31'd0, rsp_valid}, 32'd1);
        chk("R7 R10 response data", {16'd0, rsp_rdata}, {16'd0, w & lane_bits(m)});
        chk_strobes("R8 turnaround strobes", 6'b111110);
        chk("R8 not ready in turnaround", {31'd0, req_ready}, 32'd0);
        for (int t = 1; t < TRN; t++) begin
            @(negedge clk);
            chk_strobes("R8 turnaround strobes", 6'b111110);
        end
        @(negedge clk);
        chk("R7 single pulse", {31'd0, rsp_valid}, 32'd0);
        chk("R8 ready after turnaround", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        logic [17:0] pool [8];
        void'($urandom(32'h5EED_0123));
        for (int i = 0; i < 8; i++) pool[i] = $urandom;
        repeat (3) @(negedge clk);
        chk_strobes("R1 strobes in reset", 6'b111110);
        rst_n = 1'b1;
        @(negedge clk);
        chk_strobes("R1 strobes after reset", 6'b111110);
        chk("R1 ready after reset", {31'd0, req_ready}, 32'd1);
        chk("R1 no response after reset", {31'd0, rsp_valid}, 32'd0);
        // idle inputs with valid low
        req_write = 1'b1; req_mask = 2'b11;
        repeat (4) begin
            @(negedge clk);
            chk_strobes("R2 idle without valid", 6'b111110);
        end
        // directed corners
        do_write(18'h3FFFF, 16'hBEEF, 2'b11);
        do_read(18'h3FFFF, 2'b11);
        do_write(18'h00000, 16'h1234, 2'b01);
        do_read(18'h00000, 2'b11);
        do_read(18'h00000, 2'b10);
        do_write(18'h00000, 16'hFFFF, 2'b00);  // R10 empty mask write
        do_read(18'h00000, 2'b11);
        do_read(18'h00000, 2'b00);             // R10 empty mask read
        do_write(18'h12345, 16'hA0B0, 2'b10);
        do_read(18'h12345, 2'b01);
        do_write(18'h12345, 16'h0C0D, 2'b11);  // read followed at once by write
        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [17:0] a;
            a = pool[$urandom_range(0, 7)];
            if ($urandom_range(0, 1) == 1)
                do_write(a, 16'($urandom), 2'($urandom));
            else
                do_read(a, 2'($urandom));
        end
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule